// File: doc/BRIEF.md
# Sliding-Window Single-MAC FIR Filter

This block filters a stream of signed 16-bit samples through a direct-form FIR of up to 170 taps using one multiply-accumulate unit. It runs one MAC per clock over all taps for each accepted sample. Coefficients are 16-bit signed and sit in a per-tap register file, filled in order through a simple load port. The number of taps is chosen at initialisation time.

The delayed samples sit in a word RAM that is never shifted. Each new sample is written at a window pointer. The taps are read forward from that pointer, and the pointer then steps down one word. After every 32 samples the pointer has run out of headroom. A copy phase then moves the live history up by 32 words, in whole 32-word blocks, and puts the pointer back at its start.

The input is a valid/ready stream. `s_ready` drops while a sample is being filtered, while the history is being copied and while the buffer is being cleared, so the source must hold its sample until it sees ready. The output has no back-pressure: `m_valid` pulses for one cycle and the consumer must take `m_data` / `m_data_ob` in that cycle.

Top module: `fir_slide`

## Requirements
- R1: After reset, and after `init_go` is seen while idle, the block clears all 224 buffer words. This takes 224 cycles with `s_ready` low. `s_ready` is first high in the 225th cycle after the `init_go` edge. All earlier history then reads as zero.
- R2: Each `coef_valid` cycle stores `coef_data` into the next coefficient slot. Slots start at 0 after reset and after an accepted `init_go`. Writes past slot 169 are ignored. Loading may overlap the clear phase.
- R3: `cfg_taps` is latched on an accepted `init_go` and clamped. A value of 0 gives 1 tap, and values above 170 give 170 taps.
- R4: For the sample x[n] accepted as the n-th since initialisation, `m_data` is sum over k<N of c[k]*x[n-k], arithmetically shifted right by 15. N is the tap count, and samples before initialisation count as zero.
- R5: The shifted sum saturates to the signed 16-bit range, -32768..32767, instead of wrapping.
- R6: `m_data_ob` equals `m_data` + 0x8000 modulo 2^16, which is `m_data` with bit 15 inverted.
- R7: A sample is taken only on a cycle with `s_valid` and `s_ready` both high. `s_ready` is low from acceptance until the output and any copy phase are done. It is also low in any cycle with `init_go` high. Input held during those cycles has no effect.
- R8: After the output of every 32nd sample since initialisation, `s_ready` stays low for a copy phase of ceil(N/32)*32+1 cycles. After other outputs it returns high in the next cycle. Results stay correct across copy phases.
- R9: Each accepted sample yields exactly one single-cycle `m_valid` pulse. The pulse falls in the (N+2)-th cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_go | input | 1 | Start initialisation (honoured while idle) |
| cfg_taps | input | 8 | Tap count, latched with `init_go` |
| coef_valid | input | 1 | Store `coef_data` in the next coefficient slot |
| coef_data | input | 16 | Signed coefficient |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | 16 | Signed input sample |
| m_valid | output | 1 | One-cycle output strobe |
| m_data | output | 16 | Signed, saturated filter output |
| m_data_ob | output | 16 | Output in offset-binary form |

## Verification
Two collisions matter here. The first is `init_go` arriving in the same cycle as a valid input sample. The bench provokes it and judges it by the next output, which must equal the model with the sample left out. The second is coefficient loading running in the same cycles as the buffer clear. The bench loads a whole set straight after `init_go` and checks the outputs that follow against the reference convolution. Long random runs with tap counts that are not multiples of 32 cross several copy phases, and the bench checks the ready gap after each output.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [2:0] {
    ST_CLR,
    ST_IDLE,
    ST_MAC,
    ST_DRAIN,
    ST_OUT,
    ST_COPY,
    ST_CDRAIN
  } fir_state_e;
endpackage

// File: rtl/fir_coef_rf.sv
module fir_coef_rf #(
  parameter int DW = 16,
  parameter int NT = 170,
  parameter int IW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 wr_en,
  input  logic signed [DW-1:0] wr_data,
  input  logic [IW-1:0]        rd_idx,
  output logic signed [DW-1:0] rd_data
);
  logic [IW-1:0]        widx;
  logic signed [DW-1:0] regs [NT];

  always_ff @(posedge clk) begin
    if (!rst_n || restart) widx <= '0;
    else if (wr_en && widx < IW'(NT)) widx <= widx + 1'b1;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tap
    logic signed [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_en && !restart && widx == IW'(i)) q <= wr_data;
    end
    assign regs[i] = q;
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/fir_delay_ram.sv
module fir_delay_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 224,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int FRAC  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] y_sat,
  output logic [DW-1:0]        y_ob
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO = -HI - 1;

  logic signed [ACC_W-1:0] acc;
  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] sh;

  assign prod = a * b;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en) acc <= acc + ACC_W'(prod);
  end

  always_comb begin
    sh = acc >>> FRAC;
    if (sh > HI)      y_sat = HI[DW-1:0];
    else if (sh < LO) y_sat = LO[DW-1:0];
    else              y_sat = sh[DW-1:0];
  end

  assign y_ob = {~y_sat[DW-1], y_sat[DW-2:0]};
endmodule

// File: rtl/fir_slide.sv
module fir_slide import fir_pkg::*; #(
  parameter int DW       = 16,
  parameter int MAX_TAPS = 170,
  parameter int BLK      = 32,
  parameter int ACC_W    = 40,
  localparam int TW      = $clog2(MAX_TAPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_go,
  input  logic [TW-1:0] cfg_taps,
  input  logic          coef_valid,
  input  logic [DW-1:0] coef_data,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic [DW-1:0] m_data_ob
);
  localparam int NBLK  = (MAX_TAPS + BLK - 1) / BLK;
  localparam int DEPTH = (NBLK + 1) * BLK;
  localparam int AW    = $clog2(DEPTH);

  fir_state_e    state;
  logic [TW-1:0] tap_n, k, p_k;
  logic [AW-1:0] ptr, cp_src, c_dst, clr_idx, cp_words;
  logic          p_v, c_v;
  logic          accept, init_ok;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;
  logic signed [DW-1:0] coef_q;
  logic [TW-1:0] taps_clamped;

  assign s_ready = (state == ST_IDLE) && !init_go;
  assign init_ok = (state == ST_IDLE) && init_go;
  assign accept  = s_ready && s_valid;
  assign m_valid = (state == ST_OUT);

  always_comb begin
    if (cfg_taps == '0)                 taps_clamped = TW'(1);
    else if (cfg_taps > TW'(MAX_TAPS))  taps_clamped = TW'(MAX_TAPS);
    else                                taps_clamped = cfg_taps;
    cp_words = AW'(((int'(tap_n) + BLK - 1) / BLK) * BLK);
  end

  // single write port: clear, copy-back and new samples never overlap
  always_comb begin
    we = 1'b0; waddr = '0; wdata = '0;
    if (state == ST_CLR) begin
      we = 1'b1; waddr = clr_idx;
    end else if (c_v) begin
      we = 1'b1; waddr = c_dst; wdata = rdata;
    end else if (accept) begin
      we = 1'b1; waddr = ptr; wdata = s_data;
    end
    if (state == ST_MAC)       raddr = ptr + AW'(k);
    else if (state == ST_COPY) raddr = cp_src;
    else                       raddr = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_CLR;
      tap_n   <= TW'(MAX_TAPS);
      ptr     <= AW'(BLK);
      k       <= '0;
      cp_src  <= '0;
      clr_idx <= '0;
      p_v     <= 1'b0;
      p_k     <= '0;
      c_v     <= 1'b0;
      c_dst   <= '0;
    end else begin
      p_v   <= (state == ST_MAC);
      p_k   <= k;
      c_v   <= (state == ST_COPY);
      c_dst <= cp_src + AW'(BLK);
      case (state)
        ST_CLR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == AW'(DEPTH - 1)) begin
            state <= ST_IDLE;
            ptr   <= AW'(BLK);
          end
        end
        ST_IDLE: begin
          if (init_go) begin
            tap_n   <= taps_clamped;
            clr_idx <= '0;
            state   <= ST_CLR;
          end else if (s_valid) begin
            k     <= '0;
            state <= ST_MAC;
          end
        end
        ST_MAC: begin
          k <= k + 1'b1;
          if (k == tap_n - 1'b1) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_OUT;
        ST_OUT: begin
          if (ptr == AW'(1)) begin
            cp_src <= cp_words - 1'b1;
            state  <= ST_COPY;
          end else begin
            ptr   <= ptr - 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_COPY: begin
          cp_src <= cp_src - 1'b1;
          if (cp_src == '0) state <= ST_CDRAIN;
        end
        ST_CDRAIN: begin
          ptr   <= AW'(BLK);
          state <= ST_IDLE;
        end
        default: state <= ST_CLR;
      endcase
    end
  end

  fir_delay_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  fir_coef_rf #(.DW(DW), .NT(MAX_TAPS), .IW(TW)) u_coef (
    .clk(clk), .rst_n(rst_n), .restart(init_ok), .wr_en(coef_valid),
    .wr_data(coef_data), .rd_idx(p_k), .rd_data(coef_q)
  );

  fir_mac #(.DW(DW), .ACC_W(ACC_W), .FRAC(15)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(p_v),
    .a(signed'(rdata)), .b(coef_q), .y_sat(m_data), .y_ob(m_data_ob)
  );
endmodule

// File: rtl/fir_slide_chk.sv
module fir_slide_chk #(
  parameter int MAX_TAPS = 170,
  parameter int BLK      = 32,
  parameter int TW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_go,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          idle,
  input logic [TW-1:0] tap_n
);
  localparam int LB = $clog2(BLK);

  logic          pend;
  logic [TW:0]   lat;
  logic [LB-1:0] blk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; lat <= '0; blk_cnt <= '0;
    end else begin
      if (s_valid && s_ready) begin
        pend <= 1'b1; lat <= '0; blk_cnt <= blk_cnt + 1'b1;
      end else begin
        if (m_valid) pend <= 1'b0;
        if (pend) lat <= lat + 1'b1;
      end
      if (init_go && idle) blk_cnt <= '0;
    end
  end

  AST_TAPS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_n >= TW'(1)) && (tap_n <= TW'(MAX_TAPS))); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !s_ready); // R7
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid); // R9
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (pend && lat == {1'b0, tap_n} + 1'b1)); // R9
  AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_go && idle) |=> !s_ready); // R1
  AST_COPY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && blk_cnt == '0) |=> !idle); // R8
  AST_NO_COPY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && blk_cnt != '0) |=> idle); // R8
endmodule

bind fir_slide fir_slide_chk #(.MAX_TAPS(MAX_TAPS), .BLK(BLK), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_go(init_go), .s_valid(s_valid),
  .s_ready(s_ready), .m_valid(m_valid), .idle(state == fir_pkg::ST_IDLE),
  .tap_n(tap_n)
);

// File: tb/sim_fir_slide.sv
module sim_fir_slide;
  localparam int MAXT  = 170;
  localparam int BLK   = 32;
  localparam int DEPTH = ((MAXT + BLK - 1) / BLK + 1) * BLK;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_go = 1'b0;
  logic [7:0]  cfg_taps = '0;
  logic        coef_valid = 1'b0;
  logic [15:0] coef_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid;
  logic [15:0] m_data, m_data_ob;

  int cm [200];
  int xh [4096];
  int nidx, ntap;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  fir_slide u0 (
    .clk(clk), .rst_n(rst_n), .init_go(init_go), .cfg_taps(cfg_taps),
    .coef_valid(coef_valid), .coef_data(coef_data), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid),
    .m_data(m_data), .m_data_ob(m_data_ob)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_out();
    longint s = 0;
    for (int k = 0; k < ntap; k++)
      if (nidx - 1 - k >= 0) s += longint'(cm[k]) * longint'(xh[nidx - 1 - k]);
    s = s >>> 15;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  // start initialisation from a negedge; optionally present a sample in the same cycle
  task automatic do_init(input int t, input bit with_sample);
    while (!(u0.state == fir_pkg::ST_IDLE)) @(negedge clk);
    init_go = 1'b1; cfg_taps = 8'(t);
    s_valid = with_sample; s_data = 16'h4321;
    @(negedge clk);
    init_go = 1'b0; s_valid = 1'b0;
    ntap = (t == 0) ? 1 : (t > MAXT ? MAXT : t);
    nidx = 0;
  endtask

  task automatic load(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      coef_valid = 1'b1; coef_data = 16'(cm[i]);
      @(negedge clk);
    end
    coef_valid = 1'b0;
  endtask

  task automatic send(input int x, input bit garbage);
    int cnt, g, exp;
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = 16'(x);
    @(negedge clk);
    s_valid = garbage; s_data = 16'($urandom);
    xh[nidx] = x; nidx++;
    cnt = 1;
    while (!m_valid && cnt < 400) begin @(negedge clk); cnt++; end
    chk(cnt == ntap + 2, "R9 latency", cnt, ntap + 2);
    exp = ref_out();
    chk(int'($signed(m_data)) == exp, "R4/R5 output", int'($signed(m_data)), exp);
    chk(m_data_ob == (16'(exp) ^ 16'h8000), "R6 offset binary",
        int'(m_data_ob), int'(16'(exp) ^ 16'h8000));
    g = 0;
    do begin @(negedge clk); g++; end while (!s_ready && g < 400);
    s_valid = 1'b0;
    if (nidx % BLK == 0)
      chk(g == ((ntap + BLK - 1) / BLK) * BLK + 2, "R8 copy gap", g,
          ((ntap + BLK - 1) / BLK) * BLK + 2);
    else
      chk(g == 1, "R8 ready return", g, 1);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(!s_ready && !m_valid, "R1 reset state", int'(s_ready), 0);
    rst_n = 1'b1;

    // R1: clear length measured from init_go
    do_init(5, 1'b0);
    cnt = 1;
    while (!s_ready && cnt < 400) begin @(negedge clk); cnt++; end
    chk(cnt == DEPTH + 1, "R1 clear cycles", cnt, DEPTH + 1);

    // R2/R4 impulse through 5 directed taps
    cm[0] = 16384; cm[1] = -8192; cm[2] = 32767; cm[3] = 100; cm[4] = -32768;
    load(5);
    send(32767, 1'b0);
    for (int i = 0; i < 6; i++) send(0, 1'b0);

    // R7/R1: init_go collides with a valid sample; coefs reloaded during clear (R2)
    do_init(5, 1'b1);
    load(5);
    send(1000, 1'b0);
    send(-2000, 1'b1);
    send(3, 1'b0);

    // random run, 37 taps, several copy phases, garbage held while busy (R7, R8)
    do_init(37, 1'b0);
    for (int i = 0; i < 37; i++) cm[i] = int'($signed(16'($urandom)));
    load(37);
    for (int i = 0; i < 100; i++)
      send(int'($signed(16'($urandom))), (i % 7) == 3);

    // R5 saturation both ways
    do_init(4, 1'b0);
    for (int i = 0; i < 4; i++) cm[i] = 32767;
    load(4);
    for (int i = 0; i < 4; i++) send(32767, 1'b0);
    for (int i = 0; i < 5; i++) send(-32768, 1'b0);

    // R3 clamp low: 0 -> one tap (old coefs 1..3 remain nonzero)
    do_init(0, 1'b0);
    for (int i = 0; i < 4; i++) cm[i] = 12000 - 5000 * i;
    load(4);
    for (int i = 0; i < 4; i++) send(20000 - 9000 * i, 1'b0);

    // R3 clamp high and R2 write past last slot ignored
    do_init(255, 1'b0);
    for (int i = 0; i < MAXT; i++) cm[i] = int'($urandom_range(4000)) - 2000;
    cm[MAXT] = 32767;
    load(MAXT + 1);
    cm[MAXT] = 0;
    for (int i = 0; i < 70; i++)
      send(int'($signed(16'($urandom))), 1'b0);

    finish_run();
  end
endmodule